// File: doc/BRIEF.md
# Sixteen-bit Integer Execute Unit

This unit is the arithmetic, logic and shift stage of a small eight-register RISC core. It takes two register operands, a group bit from the low end of the opcode, and a three-bit function code from the low bits of the instruction word. It returns a result word and a flag that marks a reserved function code. The core writes the result back to the register file. The core uses the flag to raise an illegal-instruction condition.

There is no state, no clock and no reset. The output follows the inputs within the same cycle. Group 0 holds the additive and multiplicative operations, and group 1 holds the bitwise and shift operations. Shift distances always come from the low four bits of the second operand. All results wrap to sixteen bits, and no carry or overflow is reported.

Top module: `ral16_alu`

## Requirements
- R1: With group bit 0 and function code 3'b100, the result is the sum of the operands modulo 2^16.
- R2: With group bit 0 and function code 3'b101, the result is first operand minus second operand modulo 2^16.
- R3: With group bit 0 and function code 3'b110, the result is the low 16 bits of the product of the operands.
- R4: With group bit 1, function code 3'b000 gives bitwise OR, 3'b010 gives bitwise AND, and 3'b011 gives bitwise XOR of the operands.
- R5: With group bit 1 and function code 3'b001, the result is the bitwise inverse of the first operand, and the second operand has no effect on it.
- R6: With group bit 1 and function code 3'b100, the first operand is shifted left by the value in bits [3:0] of the second operand, and bits [15:4] of the second operand have no effect.
- R7: With group bit 1 and function code 3'b101, the first operand is shifted right by bits [3:0] of the second operand, and the vacated upper bits are filled with zeros.
- R8: With group bit 1 and function code 3'b110, the first operand is shifted right by bits [3:0] of the second operand, and the vacated upper bits are filled with copies of bit 15.
- R9: Group 0 with codes 3'b000 to 3'b011 or 3'b111, and group 1 with code 3'b111, drive the result to zero and raise the illegal flag. Every other code keeps the illegal flag low, even when its result is zero.
- R10: The result and the flag are combinational. They settle after any input change without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 16 | First operand; the value shifted or inverted |
| opd_b | input | 16 | Second operand; its low four bits give the shift distance |
| grp_sel | input | 1 | Operation group: 0 for arithmetic, 1 for logic and shift |
| fn_code | input | 3 | Function code within the group |
| res | output | 16 | Result word |
| illegal | output | 1 | High when the group and code pair is reserved |

## Verification
Two outcomes can appear in the same evaluation and look identical on the result port: a reserved code, which forces zero, and a legal operation whose true answer is zero, such as subtracting an operand from itself or multiplying 0x0100 by 0x0100. The vector table places these cases side by side, and the illegal flag is the only port that tells them apart. Each of them is judged on both the result and the flag. The random sweep draws group bits and codes from the whole space, so reserved and legal codes follow each other directly, and a reference model computed from the requirements checks both outputs.

// File: rtl/ral16_alu_pkg.sv
package ral16_alu_pkg;
  localparam int FN_W = 3;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_MUL,
    OP_OR,  OP_NOT, OP_AND, OP_XOR,
    OP_SLL, OP_SRL, OP_SRA,
    OP_BAD
  } alu_op_e;
endpackage

// File: rtl/ral16_decode.sv
module ral16_decode
  import ral16_alu_pkg::*;
(
  input  logic            grp_sel,
  input  logic [FN_W-1:0] fn_code,
  output alu_op_e         op,
  output logic            bad
);
  always_comb begin
    op = OP_BAD;
    if (!grp_sel) begin
      case (fn_code)
        3'b100:  op = OP_ADD;
        3'b101:  op = OP_SUB;
        3'b110:  op = OP_MUL;
        default: op = OP_BAD;
      endcase
    end else begin
      case (fn_code)
        3'b000:  op = OP_OR;
        3'b001:  op = OP_NOT;
        3'b010:  op = OP_AND;
        3'b011:  op = OP_XOR;
        3'b100:  op = OP_SLL;
        3'b101:  op = OP_SRL;
        3'b110:  op = OP_SRA;
        default: op = OP_BAD;
      endcase
    end
    bad = (op == OP_BAD);
  end

  // Group 1 must never reach an arithmetic operation (R4)
  always_comb begin
    if (grp_sel)
      assert_grp1_not_arith_R4: assert (op != OP_ADD && op != OP_SUB && op != OP_MUL);
  end
endmodule

// File: rtl/ral16_arith.sv
module ral16_arith #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum,
  output logic [DATA_W-1:0] diff,
  output logic [DATA_W-1:0] prod
);
  always_comb begin
    sum  = a + b;
    diff = a - b;
    prod = a * b;
  end

  logic [DATA_W-1:0] back_a;
  logic [DATA_W-1:0] fwd_a;
  always_comb begin
    back_a = diff + b;
    fwd_a  = sum - b;
    assert_sub_inverts_R2: assert (back_a == a);
    assert_add_inverts_R1: assert (fwd_a == a);
  end
endmodule

// File: rtl/ral16_shift.sv
module ral16_shift #(
  parameter int DATA_W  = 16,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  a,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  sll_out,
  output logic [DATA_W-1:0]  srl_out,
  output logic [DATA_W-1:0]  sra_out
);
  logic [DATA_W-1:0] lft [SHAMT_W+1];
  logic [DATA_W-1:0] rzf [SHAMT_W+1];
  logic [DATA_W-1:0] rsf [SHAMT_W+1];
  logic              sgn;

  assign sgn    = a[DATA_W-1];
  assign lft[0] = a;
  assign rzf[0] = a;
  assign rsf[0] = a;

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign lft[k+1] = shamt[k] ? {lft[k][DATA_W-1-STEP:0], {STEP{1'b0}}} : lft[k];
    assign rzf[k+1] = shamt[k] ? {{STEP{1'b0}}, rzf[k][DATA_W-1:STEP]} : rzf[k];
    assign rsf[k+1] = shamt[k] ? {{STEP{sgn}}, rsf[k][DATA_W-1:STEP]} : rsf[k];
  end

  assign sll_out = lft[SHAMT_W];
  assign srl_out = rzf[SHAMT_W];
  assign sra_out = rsf[SHAMT_W];

  always_comb begin
    if (shamt != '0)
      assert_srl_zero_fill_R7: assert (srl_out[DATA_W-1] == 1'b0);
    assert_sra_sign_fill_R8: assert (sra_out[DATA_W-1] == sgn);
  end
endmodule

// File: rtl/ral16_alu.sv
module ral16_alu
  import ral16_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] opd_a,
  input  logic [DATA_W-1:0] opd_b,
  input  logic              grp_sel,
  input  logic [FN_W-1:0]   fn_code,
  output logic [DATA_W-1:0] res,
  output logic              illegal
);
  localparam int SHAMT_W = $clog2(DATA_W);

  alu_op_e           op;
  logic              bad;
  logic [DATA_W-1:0] sum, diff, prod;
  logic [DATA_W-1:0] sll_v, srl_v, sra_v;

  ral16_decode u_dec (
    .grp_sel (grp_sel),
    .fn_code (fn_code),
    .op      (op),
    .bad     (bad)
  );

  ral16_arith #(.DATA_W(DATA_W)) u_arith (
    .a    (opd_a),
    .b    (opd_b),
    .sum  (sum),
    .diff (diff),
    .prod (prod)
  );

  ral16_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .a       (opd_a),
    .shamt   (opd_b[SHAMT_W-1:0]),
    .sll_out (sll_v),
    .srl_out (srl_v),
    .sra_out (sra_v)
  );

  always_comb begin
    case (op)
      OP_ADD:  res = sum;
      OP_SUB:  res = diff;
      OP_MUL:  res = prod;
      OP_OR:   res = opd_a | opd_b;
      OP_NOT:  res = ~opd_a;
      OP_AND:  res = opd_a & opd_b;
      OP_XOR:  res = opd_a ^ opd_b;
      OP_SLL:  res = sll_v;
      OP_SRL:  res = srl_v;
      OP_SRA:  res = sra_v;
      default: res = '0;
    endcase
    illegal = bad;
  end

  always_comb begin
    if (illegal)
      assert_zero_on_reserved_R9: assert (res == '0);
  end
endmodule

// File: tb/ral16_alu_test.sv
module ral16_alu_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;

  logic        clk = 1'b0;
  logic [15:0] opd_a = '0;
  logic [15:0] opd_b = '0;
  logic        grp_sel = 1'b0;
  logic [2:0]  fn_code = '0;
  logic [15:0] res;
  logic        illegal;

  int n_chk = 0;
  int n_bad = 0;

  // {grp, fn, a, b, expected result, expected flag}
  localparam logic [52:0] VEC [NV] = '{
    {1'b0, 3'd4, 16'h7FFF, 16'h0001, 16'h8000, 1'b0},
    {1'b0, 3'd4, 16'hFFFF, 16'h0001, 16'h0000, 1'b0},
    {1'b0, 3'd5, 16'h0000, 16'h0001, 16'hFFFF, 1'b0},
    {1'b0, 3'd5, 16'h8000, 16'h0001, 16'h7FFF, 1'b0},
    {1'b0, 3'd6, 16'h0100, 16'h0100, 16'h0000, 1'b0},
    {1'b0, 3'd6, 16'hFFFF, 16'h0003, 16'hFFFD, 1'b0},
    {1'b0, 3'd6, 16'h00FF, 16'h0101, 16'hFFFF, 1'b0},
    {1'b1, 3'd0, 16'hF0F0, 16'h0F0F, 16'hFFFF, 1'b0},
    {1'b1, 3'd2, 16'hF0F0, 16'hFF00, 16'hF000, 1'b0},
    {1'b1, 3'd3, 16'hAAAA, 16'hFFFF, 16'h5555, 1'b0},
    {1'b1, 3'd1, 16'h1234, 16'hFFFF, 16'hEDCB, 1'b0},
    {1'b1, 3'd1, 16'h1234, 16'h0000, 16'hEDCB, 1'b0},
    {1'b1, 3'd4, 16'h0001, 16'h000F, 16'h8000, 1'b0},
    {1'b1, 3'd4, 16'h0001, 16'h0013, 16'h0008, 1'b0},
    {1'b1, 3'd4, 16'hABCD, 16'h0010, 16'hABCD, 1'b0},
    {1'b1, 3'd5, 16'h8000, 16'h000F, 16'h0001, 1'b0},
    {1'b1, 3'd5, 16'hF000, 16'h0004, 16'h0F00, 1'b0},
    {1'b1, 3'd6, 16'h8000, 16'h000F, 16'hFFFF, 1'b0},
    {1'b1, 3'd6, 16'hF000, 16'h0004, 16'hFF00, 1'b0},
    {1'b1, 3'd6, 16'h7000, 16'h0004, 16'h0700, 1'b0},
    {1'b0, 3'd0, 16'h1234, 16'h5678, 16'h0000, 1'b1},
    {1'b0, 3'd1, 16'h1234, 16'h5678, 16'h0000, 1'b1},
    {1'b0, 3'd2, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b1},
    {1'b0, 3'd3, 16'h8000, 16'h0001, 16'h0000, 1'b1},
    {1'b0, 3'd7, 16'hFFFF, 16'h0001, 16'h0000, 1'b1},
    {1'b1, 3'd7, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b1},
    {1'b0, 3'd5, 16'h5555, 16'h5555, 16'h0000, 1'b0}
  };

  ral16_alu uut (
    .opd_a   (opd_a),
    .opd_b   (opd_b),
    .grp_sel (grp_sel),
    .fn_code (fn_code),
    .res     (res),
    .illegal (illegal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string req_tag(input logic g, input logic [2:0] f);
    if (!g) begin
      case (f)
        3'd4:    return "R1";
        3'd5:    return "R2";
        3'd6:    return "R3";
        default: return "R9";
      endcase
    end
    case (f)
      3'd0, 3'd2, 3'd3: return "R4";
      3'd1:             return "R5";
      3'd4:             return "R6";
      3'd5:             return "R7";
      3'd6:             return "R8";
      default:          return "R9";
    endcase
  endfunction

  // Reference model built from the requirement text
  function automatic logic [16:0] model(input logic g, input logic [2:0] f,
                                        input logic [15:0] a, input logic [15:0] b);
    logic [31:0] p;
    int sh;
    sh = int'(b[3:0]);
    p  = a * b;
    if (!g) begin
      case (f)
        3'd4:    return {a + b, 1'b0};
        3'd5:    return {a - b, 1'b0};
        3'd6:    return {p[15:0], 1'b0};
        default: return {16'h0000, 1'b1};
      endcase
    end
    case (f)
      3'd0:    return {a | b, 1'b0};
      3'd1:    return {~a, 1'b0};
      3'd2:    return {a & b, 1'b0};
      3'd3:    return {a ^ b, 1'b0};
      3'd4:    return {a << sh, 1'b0};
      3'd5:    return {a >> sh, 1'b0};
      3'd6:    return {16'($signed(a) >>> sh), 1'b0};
      default: return {16'h0000, 1'b1};
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] er, input logic ef);
    n_chk++;
    if (res !== er || illegal !== ef) begin
      n_bad++;
      $display("FAIL %s g=%0b fn=%0d a=%h b=%h actual res=%h ill=%0b expected res=%h ill=%0b",
               tag, grp_sel, fn_code, opd_a, opd_b, res, illegal, er, ef);
    end
  endtask

  task automatic apply(input logic g, input logic [2:0] f,
                       input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    grp_sel = g; fn_code = f; opd_a = a; opd_b = b;
    #1;
  endtask

  initial begin
    logic [16:0] m;
    // Quiescent all-zero input: group 0 code 000 is reserved (R9)
    #1;
    check("R9", 16'h0000, 1'b1);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][52], VEC[i][51:49], VEC[i][48:33], VEC[i][32:17]);
      check(req_tag(VEC[i][52], VEC[i][51:49]), VEC[i][16:1], VEC[i][0]);
    end

    // R5: second operand swept while the first is held
    for (int i = 0; i < 8; i++) begin
      apply(1'b1, 3'd1, 16'h0F35, 16'($urandom));
      check("R5", 16'hF0CA, 1'b0);
    end

    // R6: upper bits of shift operand ignored
    apply(1'b1, 3'd4, 16'h0003, 16'hFFF2);
    check("R6", 16'h000C, 1'b0);

    // R10: change inputs between clock edges and look again without an edge
    apply(1'b0, 3'd4, 16'h0010, 16'h0020);
    check("R10", 16'h0030, 1'b0);
    opd_b = 16'h0001;
    #1;
    check("R10", 16'h0011, 1'b0);
    fn_code = 3'd7;
    #1;
    check("R10", 16'h0000, 1'b1);

    // Random sweep across the whole code space against the model
    for (int i = 0; i < 3000; i++) begin
      logic g;
      logic [2:0] f;
      g = 1'($urandom);
      f = 3'($urandom);
      apply(g, f, 16'($urandom), 16'($urandom));
      m = model(g, f, opd_a, opd_b);
      check(req_tag(g, f), m[16:1], m[0]);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule